// File: doc/BRIEF.md
# Set/Clear Serial Pattern Detector

This block watches a single serial bit stream and drives one level output. While the output is low it looks for a four-bit "set" word. When that word has been received the output goes high. While the output is high it looks for a different four-bit "clear" word, and on receiving it the output drops again. Any other bit pattern leaves the level where it is. Bits arrive least significant bit first, one per clock.

Both words come from one ten-bit elaboration constant. The low nibble is the set word, the next nibble is the clear word, and the top two bits are unused. A word of all zeros becomes 0001 and a word of all ones becomes 0111 before use. An enable input acts as a synchronous reset. While it is low the machine sits in its idle state with the output low, and searching begins on the first clock where it is high.

The controller is a Moore machine with eight states: four match positions in each of the two phases. A parameter stores the three state bits either as a forward or a backward Gray count. The output is a decode of the registered state, so there is no combinational path from the serial input.

Top module: `sd_setclear_detector`

## Requirements
- R1: On any rising clock edge where `runEn` is 0, the machine returns to idle and `flagOut` is 0 after that edge. Partial matches from before that edge are discarded.
- R2: The set word is `PAT_CONST[3:0]` and the clear word is `PAT_CONST[7:4]`. Bit 0 of a word is received first and bit 3 last. `PAT_CONST[9:8]` has no effect on the output.
- R3: A word equal to 4'b0000 is used as 4'b0001, and a word equal to 4'b1111 is used as 4'b0111.
- R4: While `flagOut` is 0, it becomes 1 right after the edge that samples the last bit of the set word. The output is registered and never depends on the current `serialIn`.
- R5: While `flagOut` is 1, it becomes 0 right after the edge that samples the last bit of the clear word. No other input sequence changes `flagOut` while `runEn` is 1.
- R6: Matches may overlap. After a mismatching bit, the search resumes from the longest tail of the received bits that is still a head of the word being sought.
- R7: Each phase starts its search empty. Bits of the word that just completed are never reused toward the next word, so a change of `flagOut` needs at least four enabled bits since the previous change or since enable.
- R8: `GRAY_DOWN`=0 stores the state index as a forward Gray count (000, 001, 011, ...). `GRAY_DOWN`=1 stores it as a backward Gray count (000, 100, 101, ...). The behaviour at the ports is identical for both settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every action occurs on its rising edge |
| runEn | input | 1 | Enable; 0 holds the machine in idle with the output low |
| serialIn | input | 1 | Serial data, one bit per clock, LSB of each word first |
| flagOut | output | 1 | Level output: set by the set word, cleared by the clear word |

## Verification
The assertions check four things on every cycle. Every rise of the output is preceded by the four sampled bits that form the set word. Every enabled fall is preceded by the four bits that form the clear word. A disabled edge always leaves the output low. No change of the output happens with fewer than four bits in the current phase. Other properties only show up in the bench's scenarios: the exact overlap fallback path, substitution of degenerate words, the unused top bits, identical behaviour under both Gray encodings, and a reset that lands in the middle of a word. For these, the bench compares four differently configured instances cycle by cycle against a history-register model.

// File: rtl/sd_pkg.sv
package sd_pkg;

  localparam int PAT_W      = 4;
  localparam int PROG_W     = $clog2(PAT_W);
  localparam int NUM_STATES = 2 * PAT_W;
  localparam int STATE_W    = $clog2(NUM_STATES);

  // strobes from the pattern datapath to the phase controller
  typedef struct packed {
    logic              complete;
    logic [PROG_W-1:0] nextProg;
  } sdStrobe_t;

  // degenerate words are replaced before use
  function automatic logic [PAT_W-1:0] fixPattern(input logic [PAT_W-1:0] raw);
    if (raw == '0) return {{(PAT_W-1){1'b0}}, 1'b1};
    if (raw == '1) return {1'b0, {(PAT_W-1){1'b1}}};
    return raw;
  endfunction

  // match length after one more bit; seen[i] is the i-th received bit
  function automatic int stepProg(input logic [PAT_W-1:0] pat, input int prog,
                                  input logic bitIn);
    logic [PAT_W-1:0] seen;
    int best;
    int pos;
    logic ok;
    best = 0;
    for (int i = 0; i < PAT_W; i++) seen[i] = (i < prog) ? pat[i] : bitIn;
    for (int k = 1; k <= PAT_W; k++) begin
      if (k <= prog + 1) begin
        ok = 1'b1;
        for (int j = 0; j < PAT_W; j++) begin
          if (j < k) begin
            pos = prog + 1 - k + j;
            if (seen[pos] != pat[j]) ok = 1'b0;
          end
        end
        if (ok) best = k;
      end
    end
    return best;
  endfunction

  // state index -> stored code (forward or backward Gray count)
  function automatic logic [STATE_W-1:0] encodeState(input int idx, input bit down);
    int n;
    logic [STATE_W-1:0] v;
    n = down ? ((NUM_STATES - idx) % NUM_STATES) : idx;
    v = STATE_W'(n);
    return v ^ (v >> 1);
  endfunction

endpackage

// File: rtl/sd_pattern_unit.sv
module sd_pattern_unit
  import sd_pkg::*;
#(
  parameter int                 CONST_W   = 10,
  parameter logic [CONST_W-1:0] PAT_CONST = 10'd317
) (
  input  logic              phase,
  input  logic [PROG_W-1:0] prog,
  input  logic              bitIn,
  output sdStrobe_t         strobe
);

  localparam logic [PAT_W-1:0] SET_PAT = fixPattern(PAT_CONST[PAT_W-1:0]);
  localparam logic [PAT_W-1:0] CLR_PAT = fixPattern(PAT_CONST[2*PAT_W-1:PAT_W]);

  logic [PROG_W:0] nextTbl [NUM_STATES][2];
  logic [PROG_W:0] sel;

  // next match length for every (phase, position, bit), built at elaboration
  for (genvar ph = 0; ph < 2; ph++) begin : g_phase
    for (genvar pr = 0; pr < PAT_W; pr++) begin : g_pos
      for (genvar b = 0; b < 2; b++) begin : g_bit
        localparam logic [PAT_W-1:0] WORD = (ph == 1) ? CLR_PAT : SET_PAT;
        localparam int NXT = stepProg(WORD, pr, 1'(b));
        assign nextTbl[ph*PAT_W + pr][b] = (PROG_W+1)'(NXT);
      end
    end
  end

  always_comb begin
    sel             = nextTbl[{phase, prog}][bitIn];
    strobe.complete = (sel == (PROG_W+1)'(PAT_W));
    strobe.nextProg = sel[PROG_W-1:0];
  end

endmodule

// File: rtl/sd_phase_ctrl.sv
module sd_phase_ctrl
  import sd_pkg::*;
#(
  parameter bit GRAY_DOWN = 1'b0
) (
  input  logic              clk,
  input  logic              runEn,
  input  sdStrobe_t         strobe,
  output logic              phase,
  output logic [PROG_W-1:0] prog,
  output logic              flag
);

  logic [STATE_W-1:0] codeTbl [NUM_STATES];
  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] idxCur;
  logic [STATE_W-1:0] idxNext;

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_code
    assign codeTbl[g] = encodeState(g, GRAY_DOWN);
  end

  // decode stored code back to {phase, position}
  always_comb begin
    idxCur = '0;
    for (int i = 0; i < NUM_STATES; i++) begin
      if (stateQ == codeTbl[i]) idxCur = STATE_W'(i);
    end
  end

  assign phase = idxCur[STATE_W-1];
  assign prog  = idxCur[PROG_W-1:0];
  assign flag  = phase;

  always_comb begin
    if (strobe.complete) idxNext = {~phase, {PROG_W{1'b0}}};
    else                 idxNext = {phase, strobe.nextProg};
  end

  always_ff @(posedge clk) begin
    if (!runEn) stateQ <= codeTbl[0];
    else        stateQ <= codeTbl[idxNext];
  end

endmodule

// File: rtl/sd_setclear_detector.sv
module sd_setclear_detector
  import sd_pkg::*;
#(
  parameter int                 CONST_W   = 10,
  parameter logic [CONST_W-1:0] PAT_CONST = 10'd317,
  parameter bit                 GRAY_DOWN = 1'b0
) (
  input  logic clk,
  input  logic runEn,
  input  logic serialIn,
  output logic flagOut
);

  sdStrobe_t         strobe;
  logic              phase;
  logic [PROG_W-1:0] prog;

  sd_pattern_unit #(
    .CONST_W  (CONST_W),
    .PAT_CONST(PAT_CONST)
  ) u_pattern (
    .phase (phase),
    .prog  (prog),
    .bitIn (serialIn),
    .strobe(strobe)
  );

  sd_phase_ctrl #(
    .GRAY_DOWN(GRAY_DOWN)
  ) u_ctrl (
    .clk   (clk),
    .runEn (runEn),
    .strobe(strobe),
    .phase (phase),
    .prog  (prog),
    .flag  (flagOut)
  );

endmodule

// File: rtl/sd_setclear_checker.sv
module sd_setclear_checker
  import sd_pkg::*;
#(
  parameter int                 CONST_W   = 10,
  parameter logic [CONST_W-1:0] PAT_CONST = 10'd317
) (
  input logic clk,
  input logic runEn,
  input logic serialIn,
  input logic flagOut
);

  localparam logic [PAT_W-1:0] SET_W = fixPattern(PAT_CONST[PAT_W-1:0]);
  localparam logic [PAT_W-1:0] CLR_W = fixPattern(PAT_CONST[2*PAT_W-1:PAT_W]);

  logic [PAT_W-1:0] hist;     // hist[0] oldest, hist[PAT_W-1] newest
  logic [2:0]       phaseCnt; // enabled bits in the current phase, saturating
  logic             flagPrev;

  always_ff @(posedge clk) begin
    hist     <= {serialIn, hist[PAT_W-1:1]};
    flagPrev <= flagOut;
    if (!runEn)                 phaseCnt <= '0;
    else if (flagOut != flagPrev) phaseCnt <= 3'd1;
    else if (phaseCnt != 3'd7)  phaseCnt <= phaseCnt + 3'd1;
  end

  // R1: a disabled edge leaves the output low
  a_r1_reset_low: assert property (@(posedge clk) !runEn |=> !flagOut);

  // R4: a rise is always preceded by the set word
  a_r4_rise_on_set: assert property (@(posedge clk) disable iff (!runEn)
    $rose(flagOut) |-> (hist == SET_W));

  // R5: an enabled fall is always preceded by the clear word
  a_r5_fall_on_clear: assert property (@(posedge clk) disable iff (!runEn)
    ($fell(flagOut) && $past(runEn)) |-> (hist == CLR_W));

  // R7: every phase needs a full word of its own bits
  a_r7_phase_fresh_start: assert property (@(posedge clk) disable iff (!runEn)
    (!$stable(flagOut) && $past(runEn)) |-> (phaseCnt >= 3'(PAT_W)));

endmodule

bind sd_setclear_detector sd_setclear_checker #(
  .CONST_W  (CONST_W),
  .PAT_CONST(PAT_CONST)
) u_sd_chk (
  .clk     (clk),
  .runEn   (runEn),
  .serialIn(serialIn),
  .flagOut (flagOut)
);

// File: tb/test_sd_setclear_detector.sv
module test_sd_setclear_detector;

  localparam int CLK_PERIOD = 10;
  localparam int NDUT = 4;
  localparam logic [9:0] KCONST [NDUT] = '{10'd317, 10'd240, 10'd15, 10'd829};

  // {runEn, serialIn, expected flagOut after the edge}, default constant
  localparam int NVEC = 28;
  localparam logic [2:0] VEC [NVEC] = '{
    3'b000, 3'b010, 3'b110, 3'b110, 3'b100, 3'b110, 3'b100, 3'b110,
    3'b111, 3'b111, 3'b101, 3'b111, 3'b111, 3'b111, 3'b101, 3'b100,
    3'b110, 3'b100, 3'b110, 3'b010, 3'b110, 3'b100, 3'b110, 3'b111,
    3'b101, 3'b101, 3'b000, 3'b100
  };

  logic clk = 1'b0;
  logic runEn = 1'b0;
  logic serialIn = 1'b0;
  logic zOut [NDUT];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_setclear_detector i_sd_setclear_detector (
    .clk(clk), .runEn(runEn), .serialIn(serialIn), .flagOut(zOut[0]));
  sd_setclear_detector #(.PAT_CONST(10'd240), .GRAY_DOWN(1'b1)) iZeroSubDut (
    .clk(clk), .runEn(runEn), .serialIn(serialIn), .flagOut(zOut[1]));
  sd_setclear_detector #(.PAT_CONST(10'd15), .GRAY_DOWN(1'b0)) iOneSubDut (
    .clk(clk), .runEn(runEn), .serialIn(serialIn), .flagOut(zOut[2]));
  sd_setclear_detector #(.PAT_CONST(10'd829), .GRAY_DOWN(1'b1)) iHighBitsDut (
    .clk(clk), .runEn(runEn), .serialIn(serialIn), .flagOut(zOut[3]));

  function automatic logic [3:0] refFix(input logic [3:0] r);
    case (r)
      4'h0:    return 4'h1;
      4'hF:    return 4'h7;
      default: return r;
    endcase
  endfunction

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flagOut=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: shift history plus bit count per phase
  logic [3:0] refSet [NDUT];
  logic [3:0] refClr [NDUT];
  logic [3:0] mHist [NDUT];
  logic       mPhase [NDUT];
  int         mCnt [NDUT];
  bit         modelOn = 1'b0;

  initial begin
    for (int k = 0; k < NDUT; k++) begin
      refSet[k] = refFix(KCONST[k][3:0]);
      refClr[k] = refFix(KCONST[k][7:4]);
      mHist[k] = '0; mPhase[k] = 1'b0; mCnt[k] = 0;
    end
  end

  always @(posedge clk) begin
    for (int k = 0; k < NDUT; k++) begin
      if (!runEn) begin
        mPhase[k] = 1'b0;
        mCnt[k] = 0;
      end else begin
        logic [3:0] h;
        h = {serialIn, mHist[k][3:1]};
        mHist[k] = h;
        mCnt[k] = (mCnt[k] < 4) ? mCnt[k] + 1 : 4;
        if (mCnt[k] >= 4 && h == (mPhase[k] ? refClr[k] : refSet[k])) begin
          mPhase[k] = ~mPhase[k];
          mCnt[k] = 0;
        end
      end
    end
    if (!runEn) modelOn = 1'b1;
  end

  // cycle-by-cycle comparison of every instance against the model
  always @(posedge clk) begin
    #1;
    if (modelOn) begin
      checkBit("R6 (default word, overlap)", zOut[0], mPhase[0]);
      checkBit("R3 (zero/ones substitution)", zOut[1], mPhase[1]);
      checkBit("R3 (ones/zero substitution)", zOut[2], mPhase[2]);
      checkBit("R2 R8 (upper bits, backward Gray)", zOut[3], mPhase[3]);
    end
  end

  task automatic drive(input logic r, input logic b);
    @(negedge clk);
    runEn = r;
    serialIn = b;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1);
    for (int k = 0; k < NDUT; k++) checkBit("R1 reset state", zOut[k], 1'b0);

    // table walk on the default constant: R4 R5 R6 R7 R1
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][2], VEC[i][1]);
      checkBit("R4,R5,R6,R7,R1 vector", zOut[0], VEC[i][0]);
    end

    // R3: substitution words. zero-sub: set 1,0,0,0 clear 1,1,1,0.
    // ones-sub: set 1,1,1,0 clear 1,0,0,0.
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b0);
    checkBit("R3 0000 used as 0001 sets", zOut[1], 1'b1);
    checkBit("R3 ones-sub not yet set", zOut[2], 1'b0);
    drive(1'b1, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b0);
    checkBit("R3 1111 used as 0111 clears", zOut[1], 1'b0);
    checkBit("R3 1111 used as 0111 sets", zOut[2], 1'b1);
    drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b0);
    checkBit("R3 0000 used as 0001 clears", zOut[2], 1'b0);
    checkBit("R3 set again", zOut[1], 1'b1);

    // R1: reset while high, mid-word
    drive(1'b0, 1'b1);
    checkBit("R1 reset while high", zOut[1], 1'b0);

    // pseudo-random stream with occasional disables (model compares each cycle)
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive((lfsr[9:5] != 5'd0), lfsr[0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule